// File: doc/BRIEF.md
# Stop-Mode Entry and Wake Controller

This block decides when a small 8-bit CPU core may drop into its deepest low-power state and when it may come back out. A decoded stop instruction either parks the core, switching off both the global clock enable and the oscillator, or is reported back as a no-operation when the stop-disable bit of the condition codes is set. While parked, the block watches the reset pin, the non-maskable interrupt pin, the maskable interrupt pin and a latched edge-interrupt flag. The first qualifying source restarts the oscillator. The block keeps the CPU clock gated for a parameterised settling interval and then releases it.

The controller is a three-state machine. The states are `ST_RUN` (clocks on), `ST_HALT` (oscillator and clocks off) and `ST_SETTLE` (oscillator on, CPU clock still gated). The transitions are:
- run→halt: stop strobe with the stop-disable bit clear.
- halt→settle: any qualifying wake.
- settle→settle (restart): the reset pin goes low while settling.
- settle→run: the settle count expires.

The wake source is recorded as a two-bit code. A hint tells the CPU whether to carry on with the next instruction or to take an interrupt vector. Both stay valid until the next stop entry. All inputs are assumed to be synchronous to `clk`, which keeps running in every state.

Top module: `lp_halt_ctrl`

## Requirements
- R1: When `por_n` is released, the block is in run: `clk_en`=1, `osc_en`=1, `stop_nop`=0, `wake_cause`=00, `resume_inline`=0.
- R2: A `stop_strobe` in run with `ccr_s`=1 does not stop the core. `stop_nop` is 1 for exactly the cycle after the strobe, and `clk_en` stays 1.
- R3: A `stop_strobe` in run with `ccr_s`=0 enters halt. From the next cycle, `clk_en`=0, `osc_en`=0 and `wake_cause` reads 00.
- R4: In halt, `ext_rst_n`=0 wakes the core with `wake_cause`=11 and `resume_inline`=0. This source outranks both interrupt pins.
- R5: In halt, `xirq_n`=0 wakes the core with `wake_cause`=10 whatever `ccr_x` is. It outranks the maskable sources.
- R6: In halt, `irq_n`=0 or `irq_edge_pend`=1 wakes the core with `wake_cause`=01, but only when `ccr_i`=0. With `ccr_i`=1 these inputs are ignored and `osc_en` stays 0.
- R7: A wake raises `osc_en` in the next cycle. `clk_en` then stays 0 for exactly `SETTLE_CYCLES` cycles before returning to 1.
- R8: `resume_inline` is 1 only after a non-maskable wake taken with `ccr_x`=1. After an IRQ wake, a reset wake, or a non-maskable wake with `ccr_x`=0 it is 0.
- R9: `ext_rst_n`=0 during settling sets `wake_cause` to 11 and `resume_inline` to 0. It also restarts the full settling interval.
- R10: `wake_cause` and `resume_inline` hold their values from the wake until the next stop entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| stop_strobe | input | 1 | One-cycle pulse: stop instruction decoded |
| ccr_s | input | 1 | Stop-disable bit of the condition codes |
| ccr_i | input | 1 | Maskable interrupt mask bit |
| ccr_x | input | 1 | Non-maskable interrupt mask bit |
| irq_n | input | 1 | Maskable interrupt pin, active low |
| xirq_n | input | 1 | Non-maskable interrupt pin, active low |
| irq_edge_pend | input | 1 | Latched edge-triggered IRQ pending |
| ext_rst_n | input | 1 | External reset pin, active low |
| clk_en | output | 1 | Global CPU/peripheral clock enable |
| osc_en | output | 1 | Crystal oscillator enable |
| stop_nop | output | 1 | Stop instruction was treated as a no-op |
| wake_cause | output | 2 | 00 none, 01 IRQ, 10 XIRQ, 11 reset |
| resume_inline | output | 1 | 1: continue after stop; 0: take vector/reset |

## Verification
The bench builds the controller with `SETTLE_CYCLES` set to 5 instead of the multi-thousand default. This makes both edges of the settling window easy to hit: the last gated cycle and the first released one. It also lets thousands of random cycles go round the run→halt→settle→run loop many times. With it, a reset pulse can land in the middle of settling and restart the window, and the count can be checked precisely against the short interval.

// File: rtl/lp_halt_pkg.sv
package lp_halt_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_HALT   = 2'd1,
        ST_SETTLE = 2'd2
    } halt_state_e;

    typedef enum logic [1:0] {
        WC_NONE = 2'b00,
        WC_IRQ  = 2'b01,
        WC_XIRQ = 2'b10,
        WC_RST  = 2'b11
    } wake_cause_e;

    typedef struct packed {
        logic        hit;
        wake_cause_e cause;
        logic        inline_ok;
    } wake_req_t;

endpackage

// File: rtl/lp_wake_resolve.sv
module lp_wake_resolve
    import lp_halt_pkg::*;
(
    input  logic      ext_rst_n,
    input  logic      xirq_n,
    input  logic      irq_n,
    input  logic      irq_edge_pend,
    input  logic      ccr_i,
    input  logic      ccr_x,
    output wake_req_t req
);

    logic irq_qual;

    // maskable source: level pin or latched edge, only with mask clear
    assign irq_qual = !ccr_i && (!irq_n || irq_edge_pend);

    // fixed priority: reset, then non-maskable, then maskable
    always_comb begin
        if (!ext_rst_n) begin
            req.hit       = 1'b1;
            req.cause     = WC_RST;
            req.inline_ok = 1'b0;
        end else if (!xirq_n) begin
            req.hit       = 1'b1;
            req.cause     = WC_XIRQ;
            req.inline_ok = ccr_x;
        end else if (irq_qual) begin
            req.hit       = 1'b1;
            req.cause     = WC_IRQ;
            req.inline_ok = 1'b0;
        end else begin
            req.hit       = 1'b0;
            req.cause     = WC_NONE;
            req.inline_ok = 1'b0;
        end
    end

endmodule

// File: rtl/lp_osc_settle.sv
module lp_osc_settle #(
    parameter int unsigned SETTLE_CYCLES = 4064
) (
    input  logic clk,
    input  logic por_n,
    input  logic load,
    input  logic advance,
    output logic done
);

    localparam int unsigned CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
        end else if (advance && !done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == LAST);

    // independent span counter for the settle-window check
    logic [31:0] span_q;
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)       span_q <= '0;
        else if (load)    span_q <= '0;
        else if (advance) span_q <= span_q + 1;
    end

    // R7
    settle_len_chk: assert property (@(posedge clk) disable iff (!por_n)
        (advance && done && !load) |-> (span_q == 32'(SETTLE_CYCLES - 1)));

endmodule

// File: rtl/lp_halt_ctrl.sv
module lp_halt_ctrl
    import lp_halt_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 4064
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       stop_strobe,
    input  logic       ccr_s,
    input  logic       ccr_i,
    input  logic       ccr_x,
    input  logic       irq_n,
    input  logic       xirq_n,
    input  logic       irq_edge_pend,
    input  logic       ext_rst_n,
    output logic       clk_en,
    output logic       osc_en,
    output logic       stop_nop,
    output logic [1:0] wake_cause,
    output logic       resume_inline
);

    halt_state_e st_q, st_d;
    wake_req_t   wreq;
    wake_cause_e cause_q;
    logic        inline_q;
    logic        nop_q;
    logic        settle_load;
    logic        settle_done;
    logic        enter_halt;
    logic        nop_hit;

    lp_wake_resolve u_resolve (
        .ext_rst_n     (ext_rst_n),
        .xirq_n        (xirq_n),
        .irq_n         (irq_n),
        .irq_edge_pend (irq_edge_pend),
        .ccr_i         (ccr_i),
        .ccr_x         (ccr_x),
        .req           (wreq)
    );

    lp_osc_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk     (clk),
        .por_n   (por_n),
        .load    (settle_load),
        .advance (st_q == ST_SETTLE),
        .done    (settle_done)
    );

    assign enter_halt = (st_q == ST_RUN) && stop_strobe && !ccr_s;
    assign nop_hit    = (st_q == ST_RUN) && stop_strobe &&  ccr_s;

    // next-state and settle-counter control
    always_comb begin
        st_d        = st_q;
        settle_load = 1'b0;
        unique case (st_q)
            ST_RUN: begin
                if (enter_halt) st_d = ST_HALT;
            end
            ST_HALT: begin
                if (wreq.hit) begin
                    st_d        = ST_SETTLE;
                    settle_load = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (!ext_rst_n)       settle_load = 1'b1;
                else if (settle_done) st_d = ST_RUN;
            end
            default: st_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    // wake record and no-op pulse
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cause_q  <= WC_NONE;
            inline_q <= 1'b0;
            nop_q    <= 1'b0;
        end else begin
            nop_q <= nop_hit;
            if (enter_halt) begin
                cause_q  <= WC_NONE;
                inline_q <= 1'b0;
            end else if (st_q == ST_HALT && wreq.hit) begin
                cause_q  <= wreq.cause;
                inline_q <= wreq.inline_ok;
            end else if (st_q == ST_SETTLE && !ext_rst_n) begin
                cause_q  <= WC_RST;
                inline_q <= 1'b0;
            end
        end
    end

    // outputs per state
    always_comb begin
        unique case (st_q)
            ST_RUN:    begin clk_en = 1'b1; osc_en = 1'b1; end
            ST_HALT:   begin clk_en = 1'b0; osc_en = 1'b0; end
            ST_SETTLE: begin clk_en = 1'b0; osc_en = 1'b1; end
            default:   begin clk_en = 1'b0; osc_en = 1'b0; end
        endcase
    end

    assign stop_nop      = nop_q;
    assign wake_cause    = cause_q;
    assign resume_inline = inline_q;

    // R3
    stop_entry_chk: assert property (@(posedge clk) disable iff (!por_n)
        (st_q == ST_RUN && stop_strobe && !ccr_s) |=> (!clk_en && !osc_en && wake_cause == 2'b00));

    // R2
    nop_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
        (st_q == ST_RUN && stop_strobe && ccr_s) |=> (clk_en && stop_nop));

    // R6
    irq_mask_chk: assert property (@(posedge clk) disable iff (!por_n)
        (st_q == ST_HALT && ext_rst_n && xirq_n && ccr_i) |=> !osc_en);

    // R4
    rst_wake_chk: assert property (@(posedge clk) disable iff (!por_n)
        (st_q != ST_RUN && !ext_rst_n) |=> (wake_cause == 2'b11 && !resume_inline));

    // R8
    xirq_inline_chk: assert property (@(posedge clk) disable iff (!por_n)
        (st_q == ST_HALT && ext_rst_n && !xirq_n) |=> (wake_cause == 2'b10 && resume_inline == $past(ccr_x)));

    // R10
    cause_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (st_q == ST_RUN && !(stop_strobe && !ccr_s)) |=> ($stable(wake_cause) && $stable(resume_inline)));

endmodule

// File: tb/lp_halt_ctrl_test.sv
`timescale 1ns/1ps
module lp_halt_ctrl_test;

    localparam int SC = 5;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       stop_strobe = 1'b0, ccr_s = 1'b0, ccr_i = 1'b1, ccr_x = 1'b1;
    logic       irq_n = 1'b1, xirq_n = 1'b1, irq_edge_pend = 1'b0, ext_rst_n = 1'b1;
    logic       clk_en, osc_en, stop_nop, resume_inline;
    logic [1:0] wake_cause;

    int checks = 0;
    int fails  = 0;

    // reference model state: 0 run, 1 halt, 2 settle
    int         m_st = 0;
    int         m_cnt = 0;
    logic [1:0] m_cause = 2'b00;
    logic       m_inl = 1'b0;
    logic       m_nop = 1'b0;

    always #2.5 clk = ~clk;

    lp_halt_ctrl #(.SETTLE_CYCLES(SC)) uut (
        .clk(clk), .por_n(por_n), .stop_strobe(stop_strobe), .ccr_s(ccr_s),
        .ccr_i(ccr_i), .ccr_x(ccr_x), .irq_n(irq_n), .xirq_n(xirq_n),
        .irq_edge_pend(irq_edge_pend), .ext_rst_n(ext_rst_n),
        .clk_en(clk_en), .osc_en(osc_en), .stop_nop(stop_nop),
        .wake_cause(wake_cause), .resume_inline(resume_inline)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_clk_en();
        return m_st == 0;
    endfunction

    function automatic logic exp_osc_en();
        return m_st != 1;
    endfunction

    task automatic model_step();
        m_nop = (m_st == 0) && stop_strobe && ccr_s;
        case (m_st)
            0: if (stop_strobe && !ccr_s) begin
                   m_st = 1; m_cause = 2'b00; m_inl = 1'b0;
               end
            1: begin
                   if (!ext_rst_n) begin
                       m_st = 2; m_cnt = 0; m_cause = 2'b11; m_inl = 1'b0;
                   end else if (!xirq_n) begin
                       m_st = 2; m_cnt = 0; m_cause = 2'b10; m_inl = ccr_x;
                   end else if (!ccr_i && (!irq_n || irq_edge_pend)) begin
                       m_st = 2; m_cnt = 0; m_cause = 2'b01; m_inl = 1'b0;
                   end
               end
            default: begin
                   if (!ext_rst_n) begin
                       m_cnt = 0; m_cause = 2'b11; m_inl = 1'b0;
                   end else if (m_cnt == SC - 1) begin
                       m_st = 0;
                   end else begin
                       m_cnt++;
                   end
               end
        endcase
    endtask

    // inputs already set; advance one clock and compare against the model
    task automatic step();
        model_step();
        @(negedge clk);
        chk("R2 stop_nop",      stop_nop,      m_nop);
        chk("R7 clk_en",        clk_en,        exp_clk_en());
        chk("R3 osc_en",        osc_en,        exp_osc_en());
        chk("R10 wake_cause",   wake_cause,    m_cause);
        chk("R8 resume_inline", resume_inline, m_inl);
    endtask

    task automatic idle_pins();
        stop_strobe = 0; irq_n = 1; xirq_n = 1; irq_edge_pend = 0; ext_rst_n = 1;
    endtask

    task automatic do_stop();
        idle_pins(); stop_strobe = 1; ccr_s = 0; step(); stop_strobe = 0;
    endtask

    task automatic idle(input int n);
        idle_pins();
        for (int k = 0; k < n; k++) step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 clk_en", clk_en, 1);
        chk("R1 osc_en", osc_en, 1);
        chk("R1 stop_nop", stop_nop, 0);
        chk("R1 wake_cause", wake_cause, 0);
        chk("R1 resume_inline", resume_inline, 0);

        // R2 stop treated as no-op
        idle_pins(); stop_strobe = 1; ccr_s = 1; step();
        chk("R2 nop pulse", stop_nop, 1);
        chk("R2 clock kept", clk_en, 1);
        idle(1);
        chk("R2 nop one cycle", stop_nop, 0);

        // R3 enter stop, R6 masked IRQ ignored
        do_stop();
        chk("R3 clk off", clk_en, 0);
        chk("R3 osc off", osc_en, 0);
        ccr_i = 1; irq_n = 0; irq_edge_pend = 1;
        for (int k = 0; k < 4; k++) step();
        chk("R6 masked ignored", osc_en, 0);
        // R6 unmasked IRQ level wakes
        ccr_i = 0; step();
        chk("R6 cause irq", wake_cause, 1);
        chk("R7 osc up", osc_en, 1);
        chk("R8 irq vector", resume_inline, 0);
        idle(SC - 1);
        chk("R7 still gated", clk_en, 0);
        idle(1);
        chk("R7 released", clk_en, 1);
        idle(3);
        chk("R10 cause held", wake_cause, 1);

        // R6 edge-pending flag alone wakes
        do_stop();
        irq_edge_pend = 1; step(); irq_edge_pend = 0;
        chk("R6 pend wake", wake_cause, 1);
        idle(SC);

        // R5 XIRQ with X=1 beats IRQ; R8 inline
        ccr_x = 1; do_stop();
        xirq_n = 0; irq_n = 0; ccr_i = 0; step();
        chk("R5 cause xirq", wake_cause, 2);
        chk("R8 inline x1", resume_inline, 1);
        idle(SC);

        // R5 with X=0, R8 vector
        ccr_x = 0; do_stop();
        xirq_n = 0; step();
        chk("R5 xirq x0", wake_cause, 2);
        chk("R8 vector x0", resume_inline, 0);
        idle(SC);

        // R4 reset outranks all
        do_stop();
        ext_rst_n = 0; xirq_n = 0; irq_n = 0; step();
        chk("R4 cause rst", wake_cause, 3);
        chk("R4 no inline", resume_inline, 0);
        idle(SC);

        // R9 reset during settle restarts window
        ccr_i = 0; do_stop();
        irq_n = 0; step();
        idle(2);
        ext_rst_n = 0; step();
        chk("R9 cause upgraded", wake_cause, 3);
        idle(SC - 1);
        chk("R9 restarted gate", clk_en, 0);
        idle(1);
        chk("R9 released", clk_en, 1);
        do_stop();
        chk("R10 cleared on stop", wake_cause, 0);
        idle_pins(); xirq_n = 0; step();
        idle(SC);

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            stop_strobe   = ($urandom % 6) == 0;
            ccr_s         = ($urandom % 2) == 1;
            ccr_i         = ($urandom % 2) == 1;
            ccr_x         = ($urandom % 2) == 1;
            irq_n         = ($urandom % 5) != 0;
            xirq_n        = ($urandom % 9) != 0;
            irq_edge_pend = ($urandom % 7) == 0;
            ext_rst_n     = ($urandom % 40) != 0;
            step();
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule